// File: doc/BRIEF.md
# Two-Stage Nested Priority Interrupt Controller

This block gathers sixteen level-sensitive interrupt request lines and presents one interrupt signal to a processor. It is made of two identical eight-input priority stages. The secondary stage serves lines 8 to 15. Its combined request enters the primary stage on input 2. Line 2 therefore cannot raise a request of its own, and a device wired to it is handled as line 9. The resulting ranking, from most to least urgent, is 0, 1, 8 through 15, then 3 through 7.

The processor sees `cpu_int` and answers with a one-cycle `ack` pulse. On the next cycle the block returns the number of the granted line on `ack_id`, together with a one-cycle `ack_hit`. At that point the granted line enters service. While it is in service, requests of equal or lower rank are held back, but a more urgent request raises `cpu_int` again and can be granted on top of it. An `eoi` pulse ends service of the most urgent line currently in service, and any line it had preempted then resumes blocking. Each stage has an eight-bit mask, written through a small register port. Because the lines are level-sensitive, a line that is still high when its service ends requests again.

Top module: `irq_cascade`

## Requirements
- R1: During and after reset, no line is in service and every mask bit is 1 (masked), so `cpu_int` and `ack_hit` are low until software clears a mask.
- R2: A line whose mask bit is 1 never raises `cpu_int`. `mask_sel`=0 writes the primary mask, where bit i covers line i. `mask_sel`=1 writes the secondary mask, where bit i covers line 8+i. Primary bit 2 blocks all secondary lines.
- R3: When several eligible lines request together, the grant follows the order 0, 1, 8, 9, ..., 15, 3, 4, 5, 6, 7.
- R4: An `ack` pulse in cycle t gives `ack_hit`=1 in cycle t+1 with the 4-bit granted line number on `ack_id`. An `ack` while `cpu_int` is low gives `ack_hit`=0.
- R5: A request on line 2 is granted as line 9, and `ack_id` is never 2 when `ack_hit` is 1.
- R6: A granted line enters service. It and every line of equal or lower rank no longer raise `cpu_int`, even with its request still high.
- R7: A request that outranks every line in service raises `cpu_int` and is granted on the next `ack`.
- R8: An `eoi` pulse ends service of only the most urgent line in service. A preempted line remains in service, and `eoi` with nothing in service changes nothing.
- R9: A secondary line outranking another secondary line in service can preempt it. Primary slot 2 stays in service until every secondary line has ended.
- R10: A line that is still requesting when its service ends raises `cpu_int` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 16 | Level-sensitive request lines, index = line number |
| mask_we | input | 1 | Mask write strobe |
| mask_sel | input | 1 | 0 selects the primary mask, 1 the secondary mask |
| mask_wdata | input | 8 | Mask value, 1 = masked |
| ack | input | 1 | Processor acknowledge pulse |
| eoi | input | 1 | End-of-service pulse |
| cpu_int | output | 1 | Interrupt request to the processor |
| ack_hit | output | 1 | One-cycle flag that a grant was made |
| ack_id | output | 4 | Granted line number, valid with ack_hit |

## Verification
Four properties are checked on every cycle. A stage's in-service bit can be set only by a grant. An end-of-service removes at most one bit. While any secondary line is in service, primary slot 2 stays in service. A grant never reports line 2. The ranking order, the reroute from 2 to 9, nested preemption across and inside the cascade, masking and re-requests by lines still held high after service all depend on multi-step stimulus. These are shown only by the bench scenarios, which score each granted number against an expected queue.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int STAGE_LINES = 8;
  localparam int STAGE_IDW   = $clog2(STAGE_LINES);
  localparam int TOTAL_LINES = 2 * STAGE_LINES;
  localparam int LINE_IDW    = STAGE_IDW + 1;
  localparam int CAS_SLOT    = 2;
  localparam int REROUTE_SEC = 1;  // secondary input that also carries line 2
  typedef logic [LINE_IDW-1:0] line_id_t;
endpackage

// File: rtl/irq_lowest.sv
module irq_lowest #(
  parameter int N = 8,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] vec,
  output logic [W-1:0] idx,
  output logic         vld
);
  always_comb begin
    idx = '0;
    vld = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx = W'(i);
        vld = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_stage.sv
module irq_stage #(
  parameter int N        = 8,
  parameter int W        = $clog2(N),
  parameter bit CAS_EN   = 1'b0,
  parameter int CAS_SLOT = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req_in,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wdata,
  input  logic         take,
  input  logic         clr_en,
  input  logic         clr_hold,
  output logic         int_req,
  output logic [W-1:0] win_idx,
  output logic [N-1:0] isr,
  output logic [W-1:0] top_idx,
  output logic         isr_any
);
  logic [N-1:0] mask_q;
  logic [N-1:0] pend;
  logic [N-1:0] elig;
  logic [N-1:0] isr_nxt;

  assign pend = req_in & ~mask_q;

  irq_lowest #(.N(N), .W(W)) u_top (.vec(isr),  .idx(top_idx), .vld(isr_any));
  irq_lowest #(.N(N), .W(W)) u_win (.vec(elig), .idx(win_idx), .vld(int_req));

  // A line is eligible when it outranks everything in service; the cascade
  // slot may re-enter itself so the secondary can nest below it.
  for (genvar i = 0; i < N; i++) begin : g_elig
    if (CAS_EN && i == CAS_SLOT) begin : g_cas
      assign elig[i] = pend[i] &&
        (!isr_any || (W'(i) < top_idx) || (top_idx == W'(i)));
    end else begin : g_plain
      assign elig[i] = pend[i] && (!isr_any || (W'(i) < top_idx));
    end
  end

  always_comb begin
    isr_nxt = isr;
    if (clr_en && isr_any && !clr_hold) isr_nxt[top_idx] = 1'b0;
    if (take && int_req)                isr_nxt[win_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      isr    <= '0;
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      isr <= isr_nxt;
    end
  end

  a_r1_mask_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_q == '1 && isr == '0));
  a_r6_set_only_on_take: assert property (@(posedge clk) disable iff (rst)
    !take |=> ((isr & ~$past(isr)) == '0));
  a_r8_one_clear: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> ($countones($past(isr) & ~isr) <= 1));
endmodule

// File: rtl/irq_cascade.sv
module irq_cascade
  import irq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic [TOTAL_LINES-1:0] irq_lines,
  input  logic                   mask_we,
  input  logic                   mask_sel,
  input  logic [STAGE_LINES-1:0] mask_wdata,
  input  logic                   ack,
  input  logic                   eoi,
  output logic                   cpu_int,
  output logic                   ack_hit,
  output logic [LINE_IDW-1:0]    ack_id
);
  localparam logic [STAGE_IDW-1:0] SLOT = STAGE_IDW'(CAS_SLOT);

  logic [TOTAL_LINES-1:0] irq_q;
  logic [STAGE_LINES-1:0] p_req, s_req, p_isr, s_isr;
  logic [STAGE_IDW-1:0]   p_win, s_win, p_top, s_top;
  logic                   p_int, s_int, p_isr_any, s_isr_any;
  logic                   s_multi, s_take, s_clr;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= irq_lines;
  end

  // Secondary inputs: lines 8..15, with line 2 folded onto line 9.
  always_comb begin
    s_req = irq_q[TOTAL_LINES-1:STAGE_LINES];
    s_req[REROUTE_SEC] = s_req[REROUTE_SEC] | irq_q[CAS_SLOT];
    p_req = irq_q[STAGE_LINES-1:0];
    p_req[CAS_SLOT] = s_int;
  end

  assign s_multi = (s_isr & (s_isr - 1'b1)) != '0;
  assign s_take  = ack && p_int && (p_win == SLOT);
  assign s_clr   = eoi && p_isr_any && (p_top == SLOT);

  irq_stage #(.N(STAGE_LINES), .W(STAGE_IDW), .CAS_EN(1'b1), .CAS_SLOT(CAS_SLOT)) u_pri (
    .clk(clk), .rst(rst), .req_in(p_req),
    .mask_we(mask_we && !mask_sel), .mask_wdata(mask_wdata),
    .take(ack), .clr_en(eoi), .clr_hold((p_top == SLOT) && s_multi),
    .int_req(p_int), .win_idx(p_win), .isr(p_isr),
    .top_idx(p_top), .isr_any(p_isr_any)
  );

  irq_stage #(.N(STAGE_LINES), .W(STAGE_IDW), .CAS_EN(1'b0), .CAS_SLOT(CAS_SLOT)) u_sec (
    .clk(clk), .rst(rst), .req_in(s_req),
    .mask_we(mask_we && mask_sel), .mask_wdata(mask_wdata),
    .take(s_take), .clr_en(s_clr), .clr_hold(1'b0),
    .int_req(s_int), .win_idx(s_win), .isr(s_isr),
    .top_idx(s_top), .isr_any(s_isr_any)
  );

  assign cpu_int = p_int;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_hit <= 1'b0;
      ack_id  <= '0;
    end else begin
      ack_hit <= ack && p_int;
      if (ack && p_int)
        ack_id <= (p_win == SLOT) ? {1'b1, s_win} : {1'b0, p_win};
    end
  end

  a_r5_never_two: assert property (@(posedge clk) disable iff (rst)
    ack_hit |-> (ack_id != LINE_IDW'(CAS_SLOT)));
  a_r4_hit_after_int: assert property (@(posedge clk) disable iff (rst)
    ack_hit |-> $past(cpu_int));
  a_r9_slot_held: assert property (@(posedge clk) disable iff (rst)
    s_isr_any |-> ((p_isr & (STAGE_LINES'(1) << CAS_SLOT)) != '0));
  a_r8_sec_cleared: assert property (@(posedge clk) disable iff (rst)
    (s_clr && s_isr_any) |=> !s_isr[$past(s_top)]);
endmodule

// File: tb/irq_cascade_test.sv
`timescale 1ns/1ps
module irq_cascade_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] irq = '0;
  logic        mask_we = 1'b0, mask_sel = 1'b0;
  logic [7:0]  mask_wdata = '0;
  logic        ack = 1'b0, eoi = 1'b0;
  logic        cpu_int, ack_hit;
  logic [3:0]  ack_id;

  int tests = 0, fails = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_cascade uut (
    .clk(clk), .rst(rst), .irq_lines(irq), .mask_we(mask_we), .mask_sel(mask_sel),
    .mask_wdata(mask_wdata), .ack(ack), .eoi(eoi),
    .cpu_int(cpu_int), .ack_hit(ack_hit), .ack_id(ack_id)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_int(input bit exp, input string req);
    check(cpu_int === exp, req, int'(cpu_int), int'(exp));
  endtask

  task automatic set_mask(input bit sel, input logic [7:0] v);
    mask_sel = sel; mask_wdata = v; mask_we = 1'b1;
    tick(1);
    mask_we = 1'b0;
  endtask

  task automatic do_ack(input int exp);
    exp_q.push_back(exp);
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
    tick(1);
  endtask

  task automatic do_eoi();
    eoi = 1'b1;
    tick(1);
    eoi = 1'b0;
    tick(2);
  endtask

  // Monitor: every grant pops one expected line number.
  always @(negedge clk) begin
    if (!rst && ack_hit) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected grant", int'(ack_id), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(ack_id == 4'(e), "R3/R4 granted line", int'(ack_id), e);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    chk_int(1'b0, "R1 int after reset");
    check(ack_hit == 1'b0, "R1 ack_hit after reset", int'(ack_hit), 0);

    // R2: reset masks block everything
    irq[5] = 1'b1; tick(3);
    chk_int(1'b0, "R2 masked by reset");
    set_mask(1'b0, 8'h00); set_mask(1'b1, 8'h00); tick(1);
    chk_int(1'b1, "R2 unmasked raises int");
    do_ack(5);
    chk_int(1'b0, "R6 line5 in service");
    irq[6] = 1'b1; tick(2);
    chk_int(1'b0, "R6 lower line held");
    irq[3] = 1'b1; tick(2);
    chk_int(1'b1, "R7 preempt by 3");
    do_ack(3);
    chk_int(1'b0, "R6 after grant 3");
    irq[3] = 1'b0; do_eoi();
    chk_int(1'b0, "R8 preempted 5 still blocks 6");
    irq[5] = 1'b0; do_eoi();
    chk_int(1'b1, "R8 6 free after 5 ends");
    do_ack(6);
    do_eoi();
    chk_int(1'b1, "R10 line6 still high requests again");
    do_ack(6);
    irq[6] = 1'b0; do_eoi();
    chk_int(1'b0, "R8 all ended");

    // R3 / R9: cascade outranks 4, nesting inside the secondary
    irq[4] = 1'b1; irq[12] = 1'b1; tick(2);
    do_ack(12);
    chk_int(1'b0, "R6 4 held behind 12");
    irq[8] = 1'b1; tick(2);
    chk_int(1'b1, "R9 line8 preempts 12");
    do_ack(8);
    irq[8] = 1'b0; do_eoi();
    chk_int(1'b0, "R9 slot2 held for 12");
    irq[12] = 1'b0; do_eoi();
    chk_int(1'b1, "R9 slot2 released");
    do_ack(4);
    irq[4] = 1'b0; do_eoi();

    // R5: line 2 reroute
    irq[2] = 1'b1; tick(2);
    chk_int(1'b1, "R5 line2 request");
    do_ack(9);
    irq[2] = 1'b0; do_eoi();

    // R3: full ordering 0,1,15,7
    irq[0] = 1'b1; irq[1] = 1'b1; irq[15] = 1'b1; irq[7] = 1'b1; tick(2);
    do_ack(0);
    irq[0] = 1'b0; do_eoi(); do_ack(1);
    irq[1] = 1'b0; do_eoi(); do_ack(15);
    irq[15] = 1'b0; do_eoi(); do_ack(7);
    irq[7] = 1'b0; do_eoi();
    chk_int(1'b0, "R3 ordering drained");

    // R2: primary bit 2 masks the whole secondary
    set_mask(1'b0, 8'h04);
    irq[10] = 1'b1; tick(2);
    chk_int(1'b0, "R2 cascade masked");
    set_mask(1'b0, 8'h00); tick(1);
    chk_int(1'b1, "R2 cascade unmasked");
    do_ack(10);
    irq[10] = 1'b0; do_eoi();
    set_mask(1'b1, 8'h08);
    irq[11] = 1'b1; tick(2);
    chk_int(1'b0, "R2 line11 masked");
    set_mask(1'b1, 8'h00); tick(1);
    do_ack(11);
    irq[11] = 1'b0; do_eoi();

    // R4: spurious acknowledge
    ack = 1'b1; tick(1); ack = 1'b0;
    check(ack_hit == 1'b0, "R4 spurious ack", int'(ack_hit), 0);
    tick(1);

    // R8: eoi with nothing in service, then normal service
    do_eoi();
    chk_int(1'b0, "R8 empty eoi");
    irq[3] = 1'b1; tick(2);
    do_ack(3);
    irq[3] = 1'b0; do_eoi();

    tick(2);
    check(exp_q.size() == 0, "R4 all grants seen", exp_q.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule